// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake Controller (Resume From Suspend)

This block is the device-side link-layer sequencer that takes a transceiver with a parallel 60 MHz interface through the high-speed detection handshake when the host starts a bus reset while the device is suspended. While suspended the transceiver clock is stopped. The block therefore releases the suspend control straight from the two-bit line state, with no clocked logic in that path. It then waits for the first clock edge before it does anything else.

Once the clock runs, the block switches the transceiver to high-speed signalling with bit stuffing and NRZI turned off. It sends a Chirp K by holding transmit valid with a zero data byte for a fixed number of transceiver clock cycles. The count is chosen so that the chirp lasts at least 1 ms even when the clock is 10% fast. After the chirp it watches the line state for the host's alternating K and J chirps. Each chirp state must stay stable for a minimum number of cycles to count. After a set number of K-then-J pairs the block commits to high speed. If the pairs do not arrive within a timeout, it returns the transceiver to full-speed settings.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the block returns to the suspended state: `suspend_n` is low while `line_state` is not SE0, `tx_valid` is 0, `op_mode` is 00 (normal), `xcvr_sel` is 1 (full speed), `term_sel` is 1 (full-speed termination) and `hs_mode` is 0. This holds even when reset arrives in the middle of a handshake.
- R2: Line state encodings are SE0 = 00, J = 01 and K = 10. While suspended, SE0 on `line_state` drives `suspend_n` high combinationally, with no clock edge needed. No other output changes until a clock edge arrives.
- R3: At the first clock edge that samples SE0 while suspended, the Chirp K starts. `op_mode` becomes 10 (bit stuffing and NRZI off), `xcvr_sel` becomes 0 (high speed), `tx_valid` becomes 1 and `tx_data` is 0x00.
- R4: `tx_valid` stays high for exactly CHIRP_CYCLES consecutive cycles (default 66000). Then `tx_valid` returns to 0 and `op_mode` returns to 00, while `xcvr_sel` stays 0.
- R5: After the chirp, a host K or J counts only if `line_state` holds it for at least STABLE_CYCLES consecutive cycles (default 150). Shorter states are ignored.
- R6: After PAIRS_NEEDED counted pairs (default 3), each a K followed by a J, the block commits to high speed at the clock edge that completes the last J. From then on `hs_mode` is 1, `term_sel` is 0 and `xcvr_sel` is 0, and they stay so until reset. With fewer pairs `hs_mode` stays 0.
- R7: If high speed has not been committed TIMEOUT_CYCLES cycles after the chirp ends, the block falls back to full speed: `xcvr_sel` = 1, `term_sel` = 1, `hs_mode` = 0. Before that point `xcvr_sel` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz transceiver clock, stopped while suspended |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Bus line state from the transceiver |
| suspend_n | output | 1 | Transceiver suspend control, low = suspended |
| op_mode | output | 2 | Transceiver operating mode |
| xcvr_sel | output | 1 | Transceiver speed select, 0 = high speed |
| term_sel | output | 1 | Termination select, 1 = full-speed termination |
| tx_valid | output | 1 | Transmit valid |
| tx_data | output | 8 | Transmit data byte |
| hs_mode | output | 1 | High-speed mode committed |

## Verification
The bench builds the block with CHIRP_CYCLES = 40, STABLE_CYCLES = 6, PAIRS_NEEDED = 3 and TIMEOUT_CYCLES = 400. These values put the exact chirp length, the edge of the stability filter, the pair count and both sides of the timeout cycle within a few hundred cycles. The bench also gates the clock off to model suspend, so the combinational release can be checked while no edge arrives.

// File: rtl/hs_chirp_pkg.sv
package hs_chirp_pkg;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam logic [1:0] OPM_NORMAL  = 2'b00;
  localparam logic [1:0] OPM_RAW_TX  = 2'b10;

  typedef enum logic [2:0] {
    ST_SUSP   = 3'd0,
    ST_CHIRP  = 3'd1,
    ST_DETECT = 3'd2,
    ST_HS     = 3'd3,
    ST_FS     = 3'd4
  } hs_state_e;

  // true on the final cycle of a window of 'limit' cycles
  function automatic logic is_last(input int unsigned count, input int unsigned limit);
    return count == limit - 1;
  endfunction

  // next run length of an unchanged line state, saturating at 'limit'
  function automatic int unsigned next_run(input logic same, input int unsigned run,
                                           input int unsigned limit);
    if (!same) return 1;
    if (run >= limit) return limit;
    return run + 1;
  endfunction

endpackage

// File: rtl/hs_chirp_timer.sv
module hs_chirp_timer #(
  parameter int unsigned LIMIT = 66000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign done = en && hs_chirp_pkg::is_last(32'(cnt), LIMIT);
endmodule

// File: rtl/hs_chirp_filter.sv
module hs_chirp_filter #(
  parameter int unsigned STABLE = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] line_state,
  output logic       k_hit,
  output logic       j_hit
);
  import hs_chirp_pkg::*;
  localparam int W = $clog2(STABLE + 1);

  logic [1:0]   ls_q;
  logic [W-1:0] run;
  logic [W-1:0] run_n;
  logic         same;
  logic         hit;

  always_comb begin
    same  = (line_state == ls_q);
    run_n = W'(next_run(same, 32'(run), STABLE));
    hit   = (run_n == W'(STABLE)) && !(same && run == W'(STABLE));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ls_q <= LS_SE0;
      run  <= '0;
    end else begin
      ls_q <= line_state;
      run  <= run_n;
    end
  end

  assign k_hit = en && hit && (line_state == LS_K);
  assign j_hit = en && hit && (line_state == LS_J);
endmodule

// File: rtl/hs_chirp_ctrl.sv
module hs_chirp_ctrl #(
  parameter int unsigned CHIRP_CYCLES   = 66000,
  parameter int unsigned STABLE_CYCLES  = 150,
  parameter int unsigned PAIRS_NEEDED   = 3,
  parameter int unsigned TIMEOUT_CYCLES = 360000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  output logic       suspend_n,
  output logic [1:0] op_mode,
  output logic       xcvr_sel,
  output logic       term_sel,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       hs_mode
);
  import hs_chirp_pkg::*;
  localparam int PW = $clog2(PAIRS_NEEDED + 1);

  hs_state_e state;
  logic          want_j;
  logic [PW-1:0] pairs;

  // named internal events
  logic chirp_done;
  logic tmo_done;
  logic k_hit;
  logic j_hit;
  logic pair_done;
  logic last_pair;

  hs_chirp_timer #(.LIMIT(CHIRP_CYCLES)) u_chirp_timer (
    .clk (clk),
    .rst (rst),
    .en  (state == ST_CHIRP),
    .done(chirp_done)
  );

  hs_chirp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmo_timer (
    .clk (clk),
    .rst (rst),
    .en  (state == ST_DETECT),
    .done(tmo_done)
  );

  hs_chirp_filter #(.STABLE(STABLE_CYCLES)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .en        (state == ST_DETECT),
    .line_state(line_state),
    .k_hit     (k_hit),
    .j_hit     (j_hit)
  );

  assign pair_done = j_hit && want_j;
  assign last_pair = pair_done && (pairs == PW'(PAIRS_NEEDED - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SUSP;
      want_j <= 1'b0;
      pairs  <= '0;
    end else begin
      unique case (state)
        ST_SUSP:   if (line_state == LS_SE0) state <= ST_CHIRP;
        ST_CHIRP:  if (chirp_done) state <= ST_DETECT;
        ST_DETECT: begin
          if (k_hit && !want_j) want_j <= 1'b1;
          if (pair_done) begin
            want_j <= 1'b0;
            pairs  <= pairs + 1'b1;
          end
          if (last_pair)     state <= ST_HS;
          else if (tmo_done) state <= ST_FS;
        end
        ST_HS:     state <= ST_HS;
        ST_FS:     state <= ST_FS;
        default:   state <= ST_SUSP;
      endcase
    end
  end

  // suspend release does not wait for a clock edge
  assign suspend_n = (state != ST_SUSP) || (line_state == LS_SE0);

  assign tx_valid = (state == ST_CHIRP);
  assign tx_data  = 8'h00;
  assign op_mode  = (state == ST_CHIRP) ? OPM_RAW_TX : OPM_NORMAL;
  assign xcvr_sel = !((state == ST_CHIRP) || (state == ST_DETECT) || (state == ST_HS));
  assign term_sel = (state != ST_HS);
  assign hs_mode  = (state == ST_HS);
endmodule

// File: rtl/hs_chirp_chk.sv
module hs_chirp_chk #(
  parameter int unsigned CHIRP_CYCLES = 66000
) (
  input logic       clk,
  input logic       rst,
  input logic       suspend_n,
  input logic [1:0] op_mode,
  input logic       xcvr_sel,
  input logic       term_sel,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       hs_mode,
  input logic       j_hit
);
  logic [31:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !tx_valid) hi_run <= '0;
    else                  hi_run <= hi_run + 1;
  end

  assert_suspended_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !suspend_n |-> (!tx_valid && !hs_mode && xcvr_sel));

  assert_chirp_mode_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (op_mode == 2'b10 && !xcvr_sel && tx_data == 8'h00));

  assert_chirp_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> (hi_run == CHIRP_CYCLES));

  assert_chirp_exit_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> (op_mode == 2'b00 && !xcvr_sel));

  assert_hs_after_j_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> $past(j_hit));

  assert_hs_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    hs_mode |=> (hs_mode && !term_sel && !xcvr_sel));

  assert_fs_no_hs_R7: assert property (@(posedge clk) disable iff (rst)
    (suspend_n && xcvr_sel) |-> !hs_mode);
endmodule

bind hs_chirp_ctrl hs_chirp_chk #(.CHIRP_CYCLES(CHIRP_CYCLES)) u_hs_chirp_chk (
  .clk      (clk),
  .rst      (rst),
  .suspend_n(suspend_n),
  .op_mode  (op_mode),
  .xcvr_sel (xcvr_sel),
  .term_sel (term_sel),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .hs_mode  (hs_mode),
  .j_hit    (j_hit)
);

// File: tb/hs_chirp_ctrl_bench.sv
module hs_chirp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHIRP   = 40;
  localparam int STABLE  = 6;
  localparam int PAIRS   = 3;
  localparam int TIMEOUT = 400;

  localparam logic [1:0] SE0 = 2'b00;
  localparam logic [1:0] J   = 2'b01;
  localparam logic [1:0] K   = 2'b10;

  logic       clk_raw = 1'b0;
  logic       clk_en  = 1'b1;
  logic       clk;
  logic       rst;
  logic [1:0] ls;
  logic       suspend_n, xcvr_sel, term_sel, tx_valid, hs_mode;
  logic [1:0] op_mode;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;
  int chirp_len = 0;
  bit done = 1'b0;

  assign clk = clk_raw & clk_en;
  always #(CLK_PERIOD/2) clk_raw = ~clk_raw;

  hs_chirp_ctrl #(
    .CHIRP_CYCLES(CHIRP), .STABLE_CYCLES(STABLE),
    .PAIRS_NEEDED(PAIRS), .TIMEOUT_CYCLES(TIMEOUT)
  ) u_hs_chirp_ctrl (
    .clk(clk), .rst(rst), .line_state(ls), .suspend_n(suspend_n),
    .op_mode(op_mode), .xcvr_sel(xcvr_sel), .term_sel(term_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .hs_mode(hs_mode)
  );

  // scoreboard
  typedef enum int {S_SUSP, S_TXV, S_OPM, S_XCVR, S_TERM, S_HS, S_DATA, S_CLEN} sel_e;
  typedef struct { sel_e sel; int exp; string req; string what; } item_t;
  item_t q[$];
  event chk_ev;

  function automatic int observe(sel_e s);
    case (s)
      S_SUSP: return int'(suspend_n);
      S_TXV:  return int'(tx_valid);
      S_OPM:  return int'(op_mode);
      S_XCVR: return int'(xcvr_sel);
      S_TERM: return int'(term_sel);
      S_HS:   return int'(hs_mode);
      S_DATA: return int'(tx_data);
      default: return chirp_len;
    endcase
  endfunction

  always @(chk_ev) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s %s: got %0d expected %0d", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic want(sel_e s, int e, string req, string what);
    item_t it;
    it.sel = s; it.exp = e; it.req = req; it.what = what;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk_raw);
      #1;
    end
  endtask

  task automatic fs_idle(string req, string what);
    want(S_SUSP, 0, req, {what, " suspend_n"});
    want(S_TXV,  0, req, {what, " tx_valid"});
    want(S_OPM,  0, req, {what, " op_mode"});
    want(S_XCVR, 1, req, {what, " xcvr_sel"});
    want(S_TERM, 1, req, {what, " term_sel"});
    want(S_HS,   0, req, {what, " hs_mode"});
    flush();
  endtask

  // start from reset with a running clock, wait out the chirp; ends on first non-chirp sample
  task automatic run_chirp();
    rst = 1'b1; ls = J; step(2);
    rst = 1'b0; step(2);
    ls = SE0; step(1);
    chirp_len = 0;
    while (tx_valid) begin
      chirp_len++;
      step(1);
    end
  endtask

  task automatic host_pairs(int n, int len);
    for (int i = 0; i < n; i++) begin
      ls = K; step(len);
      ls = J; step(len);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1 finished run");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ls = J;
    step(3);
    fs_idle("R1", "reset state");
    rst = 1'b0;
    step(2);
    want(S_SUSP, 0, "R2", "J keeps suspend"); flush();

    // clock stops while suspended
    clk_en = 1'b0;
    #(CLK_PERIOD * 5);
    ls = SE0;
    #1;
    want(S_SUSP, 1, "R2", "comb release");
    want(S_TXV,  0, "R2", "no clocked action tx_valid");
    want(S_XCVR, 1, "R2", "no clocked action xcvr_sel");
    flush();
    #(CLK_PERIOD * 20);
    want(S_TXV, 0, "R2", "still idle without clock"); flush();
    @(negedge clk_raw); #1;
    clk_en = 1'b1;
    step(1);
    want(S_TXV,  1, "R3", "chirp tx_valid");
    want(S_OPM,  2, "R3", "chirp op_mode");
    want(S_XCVR, 0, "R3", "chirp xcvr_sel");
    want(S_DATA, 0, "R3", "chirp tx_data");
    want(S_TERM, 1, "R3", "chirp term_sel");
    flush();
    chirp_len = 1;
    step(1);
    while (tx_valid) begin
      chirp_len++;
      step(1);
    end
    want(S_CLEN, CHIRP, "R4", "chirp length");
    want(S_OPM,  0, "R4", "op_mode after chirp");
    want(S_XCVR, 0, "R4", "xcvr_sel after chirp");
    flush();

    host_pairs(PAIRS - 1, 8);
    ls = K; step(8);
    want(S_HS, 0, "R6", "no commit before last J"); flush();
    ls = J; step(8);
    want(S_HS,   1, "R6", "hs_mode after pairs");
    want(S_TERM, 0, "R6", "term_sel after pairs");
    want(S_XCVR, 0, "R6", "xcvr_sel after pairs");
    flush();
    step(TIMEOUT + 10);
    want(S_HS, 1, "R6", "hs_mode held"); flush();

    // short chirps ignored, then timeout
    run_chirp();
    want(S_CLEN, CHIRP, "R4", "second chirp length"); flush();
    host_pairs(PAIRS, STABLE - 2);
    ls = J;
    want(S_HS,   0, "R5", "short chirps ignored hs_mode");
    want(S_XCVR, 0, "R5", "short chirps still detecting");
    flush();
    step(TIMEOUT - 2 - PAIRS * 2 * (STABLE - 2));
    want(S_XCVR, 0, "R7", "before timeout xcvr_sel"); flush();
    step(3);
    want(S_XCVR, 1, "R7", "fallback xcvr_sel");
    want(S_TERM, 1, "R7", "fallback term_sel");
    want(S_HS,   0, "R7", "fallback hs_mode");
    flush();

    // too few pairs
    run_chirp();
    host_pairs(PAIRS - 1, STABLE);
    ls = J;
    step(TIMEOUT + 1 - (PAIRS - 1) * 2 * STABLE);
    want(S_HS,   0, "R6", "too few pairs hs_mode");
    want(S_XCVR, 1, "R7", "too few pairs fallback");
    flush();

    // reset in mid-chirp
    rst = 1'b1; ls = J; step(2);
    rst = 1'b0; step(1);
    ls = SE0; step(10);
    want(S_TXV, 1, "R3", "mid chirp"); flush();
    rst = 1'b1; ls = J; step(2);
    fs_idle("R1", "reset mid chirp");
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule